// File: doc/BRIEF.md
# Byte-Lane Pseudo-SRAM Behavioural Memory

This block is a clocked, synthesizable model of a pseudo-static RAM that presents an asynchronous-SRAM style control set. It holds 16-bit words split into two byte lanes. The active-low controls are chip select, read (output) enable, write enable, two lane enables and a sleep input that forces deep power down. The bidirectional data bus is split into a data input, a data output and one output-enable bit per byte lane. A burst input steps through a 16-word page, wrapping at the page end. A two-bit power-state output reports whether the part is in standby, active or deep power down.

All controls are sampled on the rising clock edge. A write commits on the edge where it is decoded. Read data, lane enables and power state appear one cycle after the controls that caused them. Deep power down discards the stored contents. After sleep is released, a fixed number of sampled edges is ignored while a busy flag is raised. The full part has 21 address bits. The `ADDR_W` parameter shrinks the array for simulation and defaults to 8.

Top module: `psram_lane_model`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dout` is 0, `dq_oe` is 2'b00, `pwr_state` is 2'b00 (standby) and `busy` is 0. Every word reads as 0 until it is written.
- R2: With `sleep_n` high and `sel_n` high, the next cycle shows `dq_oe` = 2'b00 and `pwr_state` = 2'b00. No write takes place, whatever the other controls are.
- R3: With `sleep_n` low, the next cycle shows `dq_oe` = 2'b00, `pwr_state` = 2'b10 (deep power down) and `busy` = 1. This overrides chip select and every other control.
- R4: With `sel_n` low and both bits of `lane_en_n` high, the next cycle shows `dq_oe` = 2'b00 and `pwr_state` = 2'b00. No write takes place.
- R5: With `sel_n` low, `rd_en_n` and `wr_en_n` both high and at least one lane enabled, the next cycle shows `dq_oe` = 2'b00 and `pwr_state` = 2'b01 (active).
- R6: A read is `sel_n` low, `wr_en_n` high, `rd_en_n` low and some lane enabled. One cycle later, `dq_oe[0]` is high if `lane_en_n[0]` was low, and then `dout[7:0]` holds the stored low byte. `dq_oe[1]` is high if `lane_en_n[1]` was low, and then `dout[15:8]` holds the stored high byte. A lane that is not enabled shows 0 on its `dout` bits.
- R7: A write is `sel_n` low and `wr_en_n` low, whatever `rd_en_n` is. It stores `din` only into the enabled lanes on that edge. The other lanes keep their value, and `dq_oe` is 2'b00 on the next cycle.
- R8: While `burst_n` is low on consecutive accesses, the first access uses `addr`. Each later access uses the previous word index plus one, modulo 16, in the same page, and ignores `addr`. The word index is `addr[3:0]` and the page is the upper address bits.
- R9: After deep power down, every word reads as 0 until it is written. A write to only one lane of such a word leaves the other lane reading 0.
- R10: Once `sleep_n` returns high, the first `RECOVER_CYC` sampled edges ignore all accesses. On those edges `dq_oe` stays 2'b00 and `pwr_state` is 2'b00. `busy` stays high until the last of them has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Active-low deep power down request |
| sel_n | input | 1 | Active-low chip select |
| rd_en_n | input | 1 | Active-low output (read) enable |
| wr_en_n | input | 1 | Active-low write enable |
| lane_en_n | input | 2 | Active-low byte lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| burst_n | input | 1 | Active-low page burst continuation |
| addr | input | ADDR_W | Word address, low 4 bits index within the page |
| din | input | 16 | Write data |
| dout | output | 16 | Read data, zero in lanes not driven |
| dq_oe | output | 2 | Per-lane output enable, models bus drive |
| pwr_state | output | 2 | 00 standby, 01 active, 10 deep power down |
| busy | output | 1 | High during deep power down and recovery |

## Verification
The hardest situation to reach is the recovery window after deep power down. Proving that accesses are ignored there needs a write that would have changed a location, followed by a read of that location once `busy` drops. The stimulus therefore stores a known word, holds `sleep_n` low with a write active, and releases it. It then writes to that word during each ignored edge, and reads it back to find the scrubbed zero rather than the recovery-time data. The page wrap is reached with a burst that starts two words before the page end, so that addresses 14, 15, 0 and 1 of one page are touched. The neighbouring page is then read to confirm it was never written.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANE_N = 2;
  localparam int unsigned WORD_W = LANE_W * LANE_N;

  typedef enum logic [1:0] {
    PWR_STANDBY = 2'b00,
    PWR_ACTIVE  = 2'b01,
    PWR_DEEP    = 2'b10
  } pwr_e;

  typedef enum logic [2:0] {
    MD_IDLE,
    MD_OUTOFF,
    MD_READ,
    MD_WRITE,
    MD_DEEP
  } mode_e;
endpackage

// File: rtl/psram_decode.sv
module psram_decode
  import psram_pkg::*;
(
  input  logic              sleep_n,
  input  logic              sel_n,
  input  logic              rd_en_n,
  input  logic              wr_en_n,
  input  logic [LANE_N-1:0] lane_en_n,
  input  logic              recovering,
  output mode_e             mode,
  output pwr_e              pwr_next
);
  always_comb begin
    mode     = MD_IDLE;
    pwr_next = PWR_STANDBY;
    if (!sleep_n) begin
      mode     = MD_DEEP;
      pwr_next = PWR_DEEP;
    end else if (recovering || sel_n || (&lane_en_n)) begin
      mode     = MD_IDLE;
      pwr_next = PWR_STANDBY;
    end else if (!wr_en_n) begin
      mode     = MD_WRITE;
      pwr_next = PWR_ACTIVE;
    end else if (!rd_en_n) begin
      mode     = MD_READ;
      pwr_next = PWR_ACTIVE;
    end else begin
      mode     = MD_OUTOFF;
      pwr_next = PWR_ACTIVE;
    end
  end
endmodule

// File: rtl/psram_power.sv
module psram_power
  import psram_pkg::*;
#(
  parameter int unsigned RECOVER_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic deep_req,
  input  pwr_e pwr_next,
  output logic recovering,
  output pwr_e pwr_state
);
  localparam int unsigned CNT_W = $clog2(RECOVER_CYC + 2);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RECOVER_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  pwr_e             pwr_q, pwr_d;

  assign recovering = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (deep_req) begin
      cnt_d = CNT_LOAD;
    end else if (recovering) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
    pwr_d = pwr_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pwr_q <= PWR_STANDBY;
    end else begin
      cnt_q <= cnt_d;
      pwr_q <= pwr_d;
    end
  end

  assign pwr_state = pwr_q;
endmodule

// File: rtl/psram_page.sv
module psram_page #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PAGE_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access,
  input  logic              burst_req,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] eff_addr
);
  logic              chain_q, chain_d;
  logic [ADDR_W-1:0] last_q, last_d;
  logic [PAGE_BITS-1:0] col_step;
  logic              follow;

  assign col_step = last_q[PAGE_BITS-1:0] + PAGE_BITS'(1);
  assign follow   = access && burst_req && chain_q;

  always_comb begin
    if (follow) begin
      eff_addr = {last_q[ADDR_W-1:PAGE_BITS], col_step};
    end else begin
      eff_addr = addr;
    end
    chain_d = access && burst_req;
    last_d  = access ? eff_addr : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= 1'b0;
      last_q  <= '0;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end
endmodule

// File: rtl/psram_array.sv
module psram_array
  import psram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_all,
  input  logic              wr_en,
  input  logic [LANE_N-1:0] lane_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] valid_q, valid_d;
  logic             word_valid;

  assign word_valid = valid_q[addr];

  always_comb begin
    valid_d = valid_q;
    if (clear_all) begin
      valid_d = '0;
    end else if (wr_en && (|lane_wr)) begin
      valid_d[addr] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  for (genvar g = 0; g < LANE_N; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic              lane_we;
    logic [LANE_W-1:0] lane_wdata;

    // An enabled lane takes new data; a disabled lane of a scrubbed word is zeroed.
    assign lane_we    = wr_en && (lane_wr[g] || !word_valid);
    assign lane_wdata = lane_wr[g] ? wdata[g*LANE_W +: LANE_W] : '0;

    always_ff @(posedge clk) begin
      if (lane_we) begin
        lane_mem[addr] <= lane_wdata;
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = word_valid ? lane_mem[addr] : '0;
  end
endmodule

// File: rtl/psram_lane_model.sv
module psram_lane_model
  import psram_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned PAGE_BITS   = 4,
  parameter int unsigned RECOVER_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_n,
  input  logic              sel_n,
  input  logic              rd_en_n,
  input  logic              wr_en_n,
  input  logic [1:0]        lane_en_n,
  input  logic              burst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  output logic [1:0]        dq_oe,
  output logic [1:0]        pwr_state,
  output logic              busy
);
  mode_e             mode;
  pwr_e              pwr_next, pwr_q;
  logic              recovering;
  logic              access;
  logic [LANE_N-1:0] lane_sel;
  logic [ADDR_W-1:0] eff_addr;
  logic [WORD_W-1:0] rdata;
  logic [WORD_W-1:0] dout_q, dout_d;
  logic [LANE_N-1:0] oe_q, oe_d;

  assign lane_sel = ~lane_en_n;
  assign access   = (mode == MD_READ) || (mode == MD_WRITE);

  psram_decode u_decode (
    .sleep_n    (sleep_n),
    .sel_n      (sel_n),
    .rd_en_n    (rd_en_n),
    .wr_en_n    (wr_en_n),
    .lane_en_n  (lane_en_n),
    .recovering (recovering),
    .mode       (mode),
    .pwr_next   (pwr_next)
  );

  psram_power #(.RECOVER_CYC(RECOVER_CYC)) u_power (
    .clk        (clk),
    .rst_n      (rst_n),
    .deep_req   (mode == MD_DEEP),
    .pwr_next   (pwr_next),
    .recovering (recovering),
    .pwr_state  (pwr_q)
  );

  psram_page #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .access    (access),
    .burst_req (!burst_n),
    .addr      (addr),
    .eff_addr  (eff_addr)
  );

  psram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (mode == MD_DEEP),
    .wr_en     (mode == MD_WRITE),
    .lane_wr   (lane_sel),
    .addr      (eff_addr),
    .wdata     (din),
    .rdata     (rdata)
  );

  for (genvar g = 0; g < LANE_N; g++) begin : g_out
    always_comb begin
      oe_d[g] = (mode == MD_READ) && lane_sel[g];
      dout_d[g*LANE_W +: LANE_W] = oe_d[g] ? rdata[g*LANE_W +: LANE_W] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      oe_q   <= '0;
    end else begin
      dout_q <= dout_d;
      oe_q   <= oe_d;
    end
  end

  assign dout      = dout_q;
  assign dq_oe     = oe_q;
  assign pwr_state = pwr_q;
  assign busy      = recovering;
endmodule

// File: rtl/psram_lane_model_chk.sv
module psram_lane_model_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sleep_n,
  input logic        sel_n,
  input logic        rd_en_n,
  input logic        wr_en_n,
  input logic [1:0]  lane_en_n,
  input logic [15:0] dout,
  input logic [1:0]  dq_oe,
  input logic [1:0]  pwr_state,
  input logic        busy
);
  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && sel_n) |=> (dq_oe == 2'b00 && pwr_state == 2'b00));

  assert_deep_override_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_n) |=> (dq_oe == 2'b00 && pwr_state == 2'b10 && busy));

  assert_no_lane_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && !sel_n && lane_en_n == 2'b11) |=> (dq_oe == 2'b00 && pwr_state == 2'b00));

  assert_output_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && !sel_n && !busy && rd_en_n && wr_en_n && lane_en_n != 2'b11)
      |=> (dq_oe == 2'b00 && pwr_state == 2'b01));

  assert_read_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && !sel_n && !busy && wr_en_n && !rd_en_n && lane_en_n != 2'b11)
      |=> (dq_oe == ~$past(lane_en_n) && pwr_state == 2'b01));

  assert_idle_lane_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((!dq_oe[0] -> dout[7:0] == 8'h00) && (!dq_oe[1] -> dout[15:8] == 8'h00)));

  assert_write_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && !sel_n && !busy && !wr_en_n) |=> (dq_oe == 2'b00));

  assert_recovery_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && busy) |=> (dq_oe == 2'b00 && pwr_state == 2'b00));
endmodule

bind psram_lane_model psram_lane_model_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep_n   (sleep_n),
  .sel_n     (sel_n),
  .rd_en_n   (rd_en_n),
  .wr_en_n   (wr_en_n),
  .lane_en_n (lane_en_n),
  .dout      (dout),
  .dq_oe     (dq_oe),
  .pwr_state (pwr_state),
  .busy      (busy)
);

// File: tb/psram_lane_model_test.sv
`timescale 1ns/1ps
module psram_lane_model_test;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned REC    = 4;

  typedef struct {
    logic [15:0] dout;
    logic [1:0]  oe;
    logic [1:0]  pwr;
    logic        busy;
    string       tag;
  } exp_t;

  logic              clk;
  logic              rst_n;
  logic              sleep_n, sel_n, rd_en_n, wr_en_n, burst_n;
  logic [1:0]        lane_en_n;
  logic [ADDR_W-1:0] addr;
  logic [15:0]       din;
  logic [15:0]       dout;
  logic [1:0]        dq_oe;
  logic [1:0]        pwr_state;
  logic              busy;

  int   n_vec;
  int   n_bad;
  bit   done;
  exp_t exp_q[$];

  psram_lane_model #(.ADDR_W(ADDR_W), .PAGE_BITS(4), .RECOVER_CYC(REC)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .sel_n(sel_n),
    .rd_en_n(rd_en_n), .wr_en_n(wr_en_n), .lane_en_n(lane_en_n),
    .burst_n(burst_n), .addr(addr), .din(din), .dout(dout),
    .dq_oe(dq_oe), .pwr_state(pwr_state), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic compare(input exp_t e);
    n_vec++;
    if (dout !== e.dout || dq_oe !== e.oe || pwr_state !== e.pwr || busy !== e.busy) begin
      n_bad++;
      $display("FAIL %s: got dout=%h oe=%b pwr=%b busy=%b, want dout=%h oe=%b pwr=%b busy=%b",
               e.tag, dout, dq_oe, pwr_state, busy, e.dout, e.oe, e.pwr, e.busy);
    end
  endtask

  // Monitor: each clock edge yields exactly one result for the item queued before it.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() != 0) begin
      compare(exp_q.pop_front());
    end
  end

  task automatic op(input logic sl, input logic se, input logic rd, input logic wr,
                    input logic [1:0] ln, input logic bu, input logic [ADDR_W-1:0] a,
                    input logic [15:0] d, input logic [15:0] edout, input logic [1:0] eoe,
                    input logic [1:0] epwr, input logic ebusy, input string tag);
    exp_t e;
    @(negedge clk);
    sleep_n = sl; sel_n = se; rd_en_n = rd; wr_en_n = wr;
    lane_en_n = ln; burst_n = bu; addr = a; din = d;
    e.dout = edout; e.oe = eoe; e.pwr = epwr; e.busy = ebusy; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wr_word(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                         input logic [1:0] ln, input logic bu, input string tag);
    op(1, 0, 1, 0, ln, bu, a, d, 16'h0000, 2'b00, 2'b01, 0, tag);
  endtask

  task automatic rd_word(input logic [ADDR_W-1:0] a, input logic [1:0] ln, input logic bu,
                         input logic [15:0] edata, input string tag);
    op(1, 0, 0, 1, ln, bu, a, 16'h0000, edata, ~ln, 2'b01, 0, tag);
  endtask

  initial begin
    n_vec = 0; n_bad = 0; done = 0;
    rst_n = 1'b0;
    sleep_n = 1; sel_n = 1; rd_en_n = 1; wr_en_n = 1; burst_n = 1;
    lane_en_n = 2'b11; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    begin
      exp_t e;
      e.dout = 16'h0000; e.oe = 2'b00; e.pwr = 2'b00; e.busy = 0; e.tag = "R1 in reset";
      compare(e);
    end
    rst_n = 1'b1;
    op(1, 1, 1, 1, 2'b11, 1, 8'h00, 16'h0, 16'h0000, 2'b00, 2'b00, 0, "R1 after reset");
    rd_word(8'h12, 2'b00, 1, 16'h0000, "R1 unwritten word reads zero");

    // R7 full write then R6 reads in each lane pattern
    wr_word(8'h12, 16'hA5C3, 2'b00, 1, "R7 word write");
    rd_word(8'h12, 2'b00, 1, 16'hA5C3, "R6 word read");
    rd_word(8'h12, 2'b10, 1, 16'h00C3, "R6 lower lane read");
    rd_word(8'h12, 2'b01, 1, 16'hA500, "R6 upper lane read");

    // R7 write wins over read enable, upper lane only
    op(1, 0, 0, 0, 2'b01, 1, 8'h12, 16'h7E99, 16'h0000, 2'b00, 2'b01, 0, "R7 write with rd_en low");
    rd_word(8'h12, 2'b00, 1, 16'h7EC3, "R7 lower lane kept");

    // R2 standby ignores write
    op(1, 1, 1, 0, 2'b00, 1, 8'h12, 16'hFFFF, 16'h0000, 2'b00, 2'b00, 0, "R2 standby write ignored");
    rd_word(8'h12, 2'b00, 1, 16'h7EC3, "R2 contents unchanged");

    // R4 no lane enabled
    op(1, 0, 1, 0, 2'b11, 1, 8'h12, 16'hFFFF, 16'h0000, 2'b00, 2'b00, 0, "R4 deselect write ignored");
    op(1, 0, 0, 1, 2'b11, 1, 8'h12, 16'h0, 16'h0000, 2'b00, 2'b00, 0, "R4 deselect read quiet");
    rd_word(8'h12, 2'b00, 1, 16'h7EC3, "R4 contents unchanged");

    // R5 output disabled
    op(1, 0, 1, 1, 2'b00, 1, 8'h12, 16'h0, 16'h0000, 2'b00, 2'b01, 0, "R5 output disabled");

    // R8 burst write wrapping from word 14 of page 3
    wr_word(8'h3E, 16'h1000, 2'b00, 0, "R8 burst write 0");
    wr_word(8'h3E, 16'h1001, 2'b00, 0, "R8 burst write 1");
    wr_word(8'h3E, 16'h1002, 2'b00, 0, "R8 burst write 2");
    wr_word(8'h3E, 16'h1003, 2'b00, 0, "R8 burst write 3");
    rd_word(8'h3E, 2'b00, 1, 16'h1000, "R8 word 3E");
    rd_word(8'h3F, 2'b00, 1, 16'h1001, "R8 word 3F");
    rd_word(8'h30, 2'b00, 1, 16'h1002, "R8 wrapped word 30");
    rd_word(8'h31, 2'b00, 1, 16'h1003, "R8 wrapped word 31");
    rd_word(8'h40, 2'b00, 1, 16'h0000, "R8 next page untouched");
    // R8 burst read across the wrap, addr input held away
    rd_word(8'h3F, 2'b00, 0, 16'h1001, "R8 burst read 0");
    rd_word(8'h77, 2'b00, 0, 16'h1002, "R8 burst read 1 wraps");
    rd_word(8'h77, 2'b00, 0, 16'h1003, "R8 burst read 2");

    // R3 deep power down overrides active write
    op(0, 0, 0, 0, 2'b00, 1, 8'h12, 16'hFFFF, 16'h0000, 2'b00, 2'b10, 1, "R3 deep power down");
    op(0, 1, 1, 1, 2'b11, 1, 8'h12, 16'hFFFF, 16'h0000, 2'b00, 2'b10, 1, "R3 deep held");

    // R10 recovery: writes ignored, busy counts down
    op(1, 0, 1, 0, 2'b00, 1, 8'h12, 16'hBEEF, 16'h0000, 2'b00, 2'b00, 1, "R10 recovery edge 1");
    op(1, 0, 1, 0, 2'b00, 1, 8'h12, 16'hBEEF, 16'h0000, 2'b00, 2'b00, 1, "R10 recovery edge 2");
    op(1, 0, 0, 1, 2'b00, 1, 8'h12, 16'h0, 16'h0000, 2'b00, 2'b00, 1, "R10 recovery read quiet");
    op(1, 0, 1, 0, 2'b00, 1, 8'h12, 16'hBEEF, 16'h0000, 2'b00, 2'b00, 0, "R10 last ignored edge");

    // R9 scrubbed contents
    rd_word(8'h12, 2'b00, 1, 16'h0000, "R9 scrubbed after deep (R10 write ignored)");
    rd_word(8'h3E, 2'b00, 1, 16'h0000, "R9 burst data scrubbed");
    wr_word(8'h3E, 16'h5A77, 2'b10, 1, "R9 lower lane write");
    rd_word(8'h3E, 2'b00, 1, 16'h0077, "R9 other lane reads zero");

    op(1, 1, 1, 1, 2'b11, 1, 8'h00, 16'h0, 16'h0000, 2'b00, 2'b00, 0, "R2 return to standby");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule